// File: doc/BRIEF.md
# SDRAM Command and Address Sequencer

This block sits between a simple request port and the command, address and mask pins of a four-bank synchronous DRAM with a 16-bit data bus, 12 row bits and 10 column bits. Each accepted request becomes one registered command on the pins in the next clock cycle, so the memory samples a stable word on its rising edge. The request kinds are row activate, column read, column write, precharge of one bank, precharge of every bank, an explicit no-operation, and entry to or exit from power-down.

The sequencer places the row or column on the address bus. It uses address bit 10 either as the auto-precharge flag on a column access or as the all-banks flag on a precharge. It drives the two byte masks so that they line up with the data beat they govern. A write mask goes out together with its write command. A read mask goes out `CAS_LAT - 2` cycles after the read command, which makes it reach the output drivers two cycles ahead of the read data. Where a write's mask and a pending read mask would need the same cycle, the write is held back at the handshake. Power-down is entered by pulling the clock enable low. The clock enable stays low until an exit request is accepted.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is high and in the cycle after it, the pins idle in deselect: chip select high, RAS/CAS/WE all high, bank 0, address 0, both masks low, clock enable high.
- R2: Request codes on `req_op` are 0 activate, 1 read, 2 write, 3 precharge one bank, 4 precharge all, 5 enter power-down, 6 exit power-down, 7 no-operation. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Its command appears on the pins for the whole following cycle. A cycle with no accepted request shows deselect (chip select high, RAS/CAS/WE high, bank and address 0).
- R3: Activate drives chip select low and RAS/CAS/WE = 0/1/1, the 12-bit row on the address bus, and the bank on the bank pins.
- R4: Read drives RAS/CAS/WE = 1/0/1 and write drives 1/0/0. On both, address bits 9:0 carry the column, bit 10 carries the auto-precharge flag, bit 11 is 0, and the bank pins carry the bank.
- R5: Precharge of one bank drives RAS/CAS/WE = 0/1/0, the bank on the bank pins, and address 0 with bit 10 low. The row, column, flag and mask inputs have no effect.
- R6: Precharge of all banks drives RAS/CAS/WE = 0/1/0, address bit 10 high with all other address bits 0, and bank 0.
- R7: The no-operation request drives chip select low and RAS/CAS/WE all high, with bank and address 0.
- R8: A write's `req_mask` appears on `mem_dqm` in the same cycle as the write command. Bit 0 blocks bits 7:0 and bit 1 blocks bits 15:8, and a high bit blocks the byte.
- R9: A read's `req_mask` appears on `mem_dqm` exactly `CAS_LAT - 2` cycles after the read command cycle. A cycle that carries neither a write mask nor a due read mask drives `mem_dqm` = 0.
- R10: A write is not accepted (`req_ready` low) when its mask cycle would coincide with a pending read mask. It is accepted in the first cycle that is free.
- R11: An accepted power-down entry drives clock enable low from the next cycle on, and it stays low. While clock enable is low, `req_ready` is high only for the exit code and the pins show deselect. An entry request is held back while a read mask is still pending.
- R12: An accepted exit request drives clock enable high in the next cycle, and requests are then accepted and encoded as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; memory samples pins on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 3 | Request code (see R2) |
| req_bank | input | 2 | Target bank |
| req_row | input | 12 | Row address for activate |
| req_col | input | 10 | Column address for read/write |
| req_apc | input | 1 | Auto-precharge flag for read/write |
| req_mask | input | 2 | Byte masks for the data beat, high blocks |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 2 | Bank select |
| mem_addr | output | 12 | Address bus |
| mem_cke | output | 1 | Clock enable |
| mem_dqm | output | 2 | Byte masks, bit 1 upper byte |

## Verification
Two functions can want the mask pins in the same cycle: the delayed mask of an earlier read and the immediate mask of a write issued right after it. With the default read latency of three, this collision is provoked by presenting a write on the cycle right after an accepted read. It is judged by seeing `req_ready` low for that cycle, the pins showing deselect while the read's mask is on `mem_dqm`, and the write with its own mask appearing one cycle later. Power-down entry racing a pending read mask is provoked the same way, and it is judged by the stalled handshake and by the clock enable falling only once the mask has gone out.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    localparam int ROW_W  = 12;
    localparam int COL_W  = 10;
    localparam int BANK_W = 2;
    localparam int MASK_W = 2;
    localparam int ADDR_W = ROW_W;
    localparam int AP_BIT = 10;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ACT    = 3'd0,
        OP_RD     = 3'd1,
        OP_WR     = 3'd2,
        OP_PRE    = 3'd3,
        OP_PREALL = 3'd4,
        OP_PDN    = 3'd5,
        OP_PUP    = 3'd6,
        OP_NOP    = 3'd7
    } req_op_e;

    // {ras_n, cas_n, we_n}
    typedef logic [2:0] cmd_t;
    localparam cmd_t CMD_NOP = 3'b111;
    localparam cmd_t CMD_ACT = 3'b011;
    localparam cmd_t CMD_RD  = 3'b101;
    localparam cmd_t CMD_WR  = 3'b100;
    localparam cmd_t CMD_PRE = 3'b010;

    typedef struct packed {
        logic              cs_n;
        cmd_t              cmd;
        logic [BANK_W-1:0] ba;
        logic [ADDR_W-1:0] addr;
    } pin_cmd_t;

    function automatic pin_cmd_t deselect_word();
        pin_cmd_t w;
        w.cs_n = 1'b1;
        w.cmd  = CMD_NOP;
        w.ba   = '0;
        w.addr = '0;
        return w;
    endfunction

    function automatic pin_cmd_t issue_word(cmd_t c, logic [BANK_W-1:0] b,
                                            logic [ADDR_W-1:0] a);
        pin_cmd_t w;
        w.cs_n = 1'b0;
        w.cmd  = c;
        w.ba   = b;
        w.addr = a;
        return w;
    endfunction

endpackage

// File: rtl/sdram_cmd_encode.sv
module sdram_cmd_encode
    import sdram_seq_pkg::*;
(
    input  req_op_e           op,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic              apc,
    output pin_cmd_t          word
);
    logic [ADDR_W-1:0] col_addr;
    logic [ADDR_W-1:0] all_addr;

    always_comb begin
        col_addr                = '0;
        col_addr[COL_W-1:0]     = col;
        col_addr[AP_BIT]        = apc;
        all_addr                = '0;
        all_addr[AP_BIT]        = 1'b1;
    end

    always_comb begin
        case (op)
            OP_ACT:    word = issue_word(CMD_ACT, bank, row);
            OP_RD:     word = issue_word(CMD_RD,  bank, col_addr);
            OP_WR:     word = issue_word(CMD_WR,  bank, col_addr);
            OP_PRE:    word = issue_word(CMD_PRE, bank, '0);
            OP_PREALL: word = issue_word(CMD_PRE, '0,   all_addr);
            OP_NOP:    word = issue_word(CMD_NOP, '0,   '0);
            default:   word = deselect_word();
        endcase
    end
endmodule

// File: rtl/sdram_mask_align.sv
module sdram_mask_align
    import sdram_seq_pkg::*;
#(
    parameter int DELAY = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_push,
    input  logic [MASK_W-1:0] rd_mask,
    input  logic              wr_push,
    input  logic [MASK_W-1:0] wr_mask,
    output logic [MASK_W-1:0] dqm_next,
    output logic              slot_busy,
    output logic              rd_pending
);
    generate
        if (DELAY == 0) begin : g_direct
            assign slot_busy  = 1'b0;
            assign rd_pending = 1'b0;
            always_comb begin
                if (rd_push)      dqm_next = rd_mask;
                else if (wr_push) dqm_next = wr_mask;
                else              dqm_next = '0;
            end
        end else begin : g_pipe
            logic              vld [DELAY];
            logic [MASK_W-1:0] msk [DELAY];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DELAY; i++) begin
                        vld[i] <= 1'b0;
                        msk[i] <= '0;
                    end
                end else begin
                    vld[0] <= rd_push;
                    msk[0] <= rd_mask;
                    for (int i = 1; i < DELAY; i++) begin
                        vld[i] <= vld[i-1];
                        msk[i] <= msk[i-1];
                    end
                end
            end

            assign slot_busy = vld[DELAY-1];

            always_comb begin
                rd_pending = 1'b0;
                for (int i = 0; i < DELAY; i++) rd_pending = rd_pending | vld[i];
            end

            always_comb begin
                if (vld[DELAY-1]) dqm_next = msk[DELAY-1];
                else if (wr_push) dqm_next = wr_mask;
                else              dqm_next = '0;
            end
        end
    endgenerate
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int CAS_LAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [OP_W-1:0]   req_op,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_apc,
    input  logic [MASK_W-1:0] req_mask,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [BANK_W-1:0] mem_ba,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cke,
    output logic [MASK_W-1:0] mem_dqm
);
    localparam int MASK_DELAY = (CAS_LAT > 2) ? CAS_LAT - 2 : 0;

    req_op_e           op;
    pin_cmd_t          enc_word;
    pin_cmd_t          word_q;
    logic [MASK_W-1:0] dqm_next;
    logic [MASK_W-1:0] dqm_q;
    logic              cke_q;
    logic              slot_busy;
    logic              rd_pending;
    logic              fire;

    assign op = req_op_e'(req_op);

    always_comb begin
        if (!cke_q)            req_ready = (op == OP_PUP);
        else if (op == OP_WR)  req_ready = !slot_busy;
        else if (op == OP_PDN) req_ready = !rd_pending;
        else                   req_ready = 1'b1;
    end

    assign fire = req_valid && req_ready;

    sdram_cmd_encode u_enc (
        .op   (op),
        .bank (req_bank),
        .row  (req_row),
        .col  (req_col),
        .apc  (req_apc),
        .word (enc_word)
    );

    sdram_mask_align #(.DELAY(MASK_DELAY)) u_mask (
        .clk        (clk),
        .rst        (rst),
        .rd_push    (fire && op == OP_RD),
        .rd_mask    (req_mask),
        .wr_push    (fire && op == OP_WR),
        .wr_mask    (req_mask),
        .dqm_next   (dqm_next),
        .slot_busy  (slot_busy),
        .rd_pending (rd_pending)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= deselect_word();
            dqm_q  <= '0;
            cke_q  <= 1'b1;
        end else begin
            word_q <= fire ? enc_word : deselect_word();
            dqm_q  <= dqm_next;
            if (fire && op == OP_PDN)      cke_q <= 1'b0;
            else if (fire && op == OP_PUP) cke_q <= 1'b1;
        end
    end

    assign mem_cs_n  = word_q.cs_n;
    assign mem_ras_n = word_q.cmd[2];
    assign mem_cas_n = word_q.cmd[1];
    assign mem_we_n  = word_q.cmd[0];
    assign mem_ba    = word_q.ba;
    assign mem_addr  = word_q.addr;
    assign mem_cke   = cke_q;
    assign mem_dqm   = dqm_q;
endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk
    import sdram_seq_pkg::*;
#(
    parameter int CAS_LAT = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [OP_W-1:0]   req_op,
    input logic [BANK_W-1:0] req_bank,
    input logic [ROW_W-1:0]  req_row,
    input logic [MASK_W-1:0] req_mask,
    input logic              mem_cs_n,
    input logic              mem_ras_n,
    input logic              mem_cas_n,
    input logic              mem_we_n,
    input logic [BANK_W-1:0] mem_ba,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cke,
    input logic [MASK_W-1:0] mem_dqm
);
    logic acc;
    assign acc = req_valid && req_ready;

    p_idle_deselect_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(acc) |-> (mem_cs_n && mem_ras_n && mem_cas_n && mem_we_n));

    p_act_word_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(acc && req_op == OP_ACT)) |->
        ({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == 4'b0011
         && mem_addr == $past(req_row) && mem_ba == $past(req_bank)));

    p_preall_a10_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(acc && req_op == OP_PREALL)) |->
        (mem_addr[AP_BIT] && mem_ba == '0 && !mem_cs_n));

    p_wr_mask_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(acc && req_op == OP_WR)) |->
        (mem_dqm == $past(req_mask)));

    p_pdn_ready_r11: assert property (@(posedge clk) disable iff (rst)
        (!mem_cke && req_op != OP_PUP) |-> !req_ready);

    p_cke_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!mem_cke && !(acc && req_op == OP_PUP)) |=> !mem_cke);

    p_cke_wake_r12: assert property (@(posedge clk) disable iff (rst)
        (!mem_cke && acc && req_op == OP_PUP) |=> mem_cke);

    generate
        if (CAS_LAT == 3) begin : g_lat3
            p_wr_stall_r10: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(acc && req_op == OP_RD) && req_op == OP_WR)
                |-> !req_ready);
        end
    endgenerate
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(.CAS_LAT(CAS_LAT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_bank  (req_bank),
    .req_row   (req_row),
    .req_mask  (req_mask),
    .mem_cs_n  (mem_cs_n),
    .mem_ras_n (mem_ras_n),
    .mem_cas_n (mem_cas_n),
    .mem_we_n  (mem_we_n),
    .mem_ba    (mem_ba),
    .mem_addr  (mem_addr),
    .mem_cke   (mem_cke),
    .mem_dqm   (mem_dqm)
);

// File: tb/sim_sdram_cmd_seq.sv
module sim_sdram_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    typedef struct packed {
        logic [3:0]  rq;
        logic [2:0]  op;
        logic [1:0]  bank;
        logic [11:0] row;
        logic [9:0]  col;
        logic        apc;
        logic [1:0]  mask;
        logic [3:0]  x_cmd;
        logic [1:0]  x_ba;
        logic [11:0] x_addr;
        logic [1:0]  x_dqm;
    } vec_t;

    // x_cmd = {cs_n, ras_n, cas_n, we_n}; x_dqm is the mask seen in that vector's pin cycle
    localparam vec_t VECS [NVEC] = '{
        '{4'd3, 3'd0, 2'd1, 12'hABC, 10'h000, 1'b0, 2'b00, 4'b0011, 2'd1, 12'hABC, 2'b00}, // R3
        '{4'd4, 3'd1, 2'd1, 12'h000, 10'h155, 1'b1, 2'b10, 4'b0101, 2'd1, 12'h555, 2'b00}, // R4
        '{4'd9, 3'd7, 2'd2, 12'hFFF, 10'h3FF, 1'b1, 2'b11, 4'b0111, 2'd0, 12'h000, 2'b10}, // R7 R9
        '{4'd8, 3'd2, 2'd2, 12'h000, 10'h3FF, 1'b0, 2'b01, 4'b0100, 2'd2, 12'h3FF, 2'b01}, // R4 R8
        '{4'd5, 3'd3, 2'd3, 12'hFFF, 10'h3FF, 1'b1, 2'b11, 4'b0010, 2'd3, 12'h000, 2'b00}, // R5
        '{4'd6, 3'd4, 2'd2, 12'hFFF, 10'h2AA, 1'b0, 2'b00, 4'b0010, 2'd0, 12'h400, 2'b00}, // R6
        '{4'd4, 3'd1, 2'd0, 12'h000, 10'h000, 1'b0, 2'b11, 4'b0101, 2'd0, 12'h000, 2'b00}, // R4
        '{4'd9, 3'd1, 2'd3, 12'h000, 10'h2AA, 1'b1, 2'b01, 4'b0101, 2'd3, 12'h6AA, 2'b11}, // R9
        '{4'd9, 3'd7, 2'd0, 12'h000, 10'h000, 1'b0, 2'b00, 4'b0111, 2'd0, 12'h000, 2'b01}, // R9
        '{4'd8, 3'd2, 2'd1, 12'h000, 10'h001, 1'b1, 2'b11, 4'b0100, 2'd1, 12'h401, 2'b11}  // R8
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [2:0]  req_op;
    logic [1:0]  req_bank;
    logic [11:0] req_row;
    logic [9:0]  req_col;
    logic        req_apc;
    logic [1:0]  req_mask;
    logic        mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
    logic [1:0]  mem_ba;
    logic [11:0] mem_addr;
    logic        mem_cke;
    logic [1:0]  mem_dqm;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_seq u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_apc(req_apc), .req_mask(req_mask), .mem_cs_n(mem_cs_n),
        .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
        .mem_ba(mem_ba), .mem_addr(mem_addr), .mem_cke(mem_cke), .mem_dqm(mem_dqm)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int cmd4();
        return {28'd0, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
    endfunction

    task automatic drive(input logic v, input logic [2:0] op, input logic [1:0] b,
                         input logic [11:0] r, input logic [9:0] c, input logic a,
                         input logic [1:0] m);
        req_valid = v; req_op = op; req_bank = b; req_row = r;
        req_col = c; req_apc = a; req_mask = m;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, 3'd7, 0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 cmd", cmd4(), 4'b1111);
        chk("R1 cke", mem_cke, 1);
        chk("R1 dqm", mem_dqm, 0);
        chk("R1 addr", mem_addr, 0);
        rst = 1'b0;
        step();
        chk("R1 cmd after release", cmd4(), 4'b1111);

        // table walk: back-to-back requests
        for (int i = 0; i < NVEC; i++) begin
            drive(1'b1, VECS[i].op, VECS[i].bank, VECS[i].row, VECS[i].col,
                  VECS[i].apc, VECS[i].mask);
            #1;
            chk($sformatf("R2 ready vec%0d", i), req_ready, 1);
            step();
            chk($sformatf("R%0d cmd vec%0d", VECS[i].rq, i), cmd4(), VECS[i].x_cmd);
            chk($sformatf("R%0d ba vec%0d", VECS[i].rq, i), mem_ba, VECS[i].x_ba);
            chk($sformatf("R%0d addr vec%0d", VECS[i].rq, i), mem_addr, VECS[i].x_addr);
            chk($sformatf("R%0d dqm vec%0d", VECS[i].rq, i), mem_dqm, VECS[i].x_dqm);
        end
        drive(1'b0, 3'd7, 0, 0, 0, 0, 0);
        step();
        chk("R2 idle deselect", cmd4(), 4'b1111);
        chk("R9 idle dqm", mem_dqm, 0);

        // R10: write right after read collides with read mask slot
        drive(1'b1, 3'd1, 2'd0, 0, 10'd5, 1'b0, 2'b11);
        step();
        drive(1'b1, 3'd2, 2'd1, 0, 10'd9, 1'b0, 2'b10);
        #1;
        chk("R10 write stalled", req_ready, 0);
        step();
        chk("R10 no command while stalled", mem_cs_n, 1);
        chk("R9 read mask out", mem_dqm, 2'b11);
        #1;
        chk("R10 write ready next", req_ready, 1);
        step();
        chk("R10 write issued", cmd4(), 4'b0100);
        chk("R8 write mask", mem_dqm, 2'b10);
        chk("R4 write col", mem_addr, 12'h009);

        // R11: power-down entry held back while read mask pending
        drive(1'b1, 3'd1, 2'd2, 0, 10'd1, 1'b0, 2'b00);
        step();
        drive(1'b1, 3'd5, 0, 0, 0, 0, 0);
        #1;
        chk("R11 entry stalled", req_ready, 0);
        step();
        #1;
        chk("R11 entry ready", req_ready, 1);
        step();
        chk("R11 cke low", mem_cke, 0);
        chk("R11 deselect", mem_cs_n, 1);
        drive(1'b1, 3'd0, 2'd1, 12'h777, 0, 0, 0);
        #1;
        chk("R11 ready low in power-down", req_ready, 0);
        step();
        chk("R11 cke held", mem_cke, 0);
        chk("R11 act ignored", mem_cs_n, 1);
        drive(1'b1, 3'd6, 0, 0, 0, 0, 0);
        #1;
        chk("R12 exit ready", req_ready, 1);
        step();
        chk("R12 cke high", mem_cke, 1);
        drive(1'b1, 3'd0, 2'd2, 12'h123, 0, 0, 0);
        step();
        chk("R12 act after exit", cmd4(), 4'b0011);
        chk("R12 row after exit", mem_addr, 12'h123);
        chk("R12 bank after exit", mem_ba, 2);

        // R1: reset while in power-down restores clock enable
        drive(1'b1, 3'd5, 0, 0, 0, 0, 0);
        step();
        chk("R11 cke low again", mem_cke, 0);
        drive(1'b0, 3'd7, 0, 0, 0, 0, 0);
        rst = 1'b1;
        step();
        chk("R1 cke after reset", mem_cke, 1);
        chk("R1 cmd after reset", cmd4(), 4'b1111);
        rst = 1'b0;
        step();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule